// File: doc/BRIEF.md
# Paged Host Register Bank for a Network Controller

This block is the host-facing register file of a network controller. A host reaches it through a synchronous 16-bit port with a word offset, two byte enables and separate read and write strobes. A paging register picks one of eight pages. The words at offsets 0x00 to 0x06 respond the same way on every page: a fixed hardware identifier, the paging register, and two option words. Offsets from 0x08 upward are decoded through the current page. In this block only the statistics page decodes any of them.

The option words are not written with plain stores. Each byte lane holds a set/clear flag in its lowest bit. The other bits written as 1 in that lane are set or cleared together according to the flag, and bits written as 0 keep their value. Two command bits in the high option word are raised by the host and dropped by completion pulses from the datapath. Three statistics counters on the statistics page count pulses from the datapath, stop at all-ones, and return to zero when the host reads them.

Top module: `netreg_bank`

## Requirements
- R1: After reset the page is 0, both option words are 0x0000, `core_rst_n` is 0, `bus_rdata` is 0 and every statistics counter reads 0.
- R2: A write to offset 0x02 with byte enable 0 set loads bits 3:0 as the new page when that value is 0 to 7. Values 8 to 15 leave the page unchanged. A read of 0x02 returns the card identifier 0x535 in bits 15:4, 0 in bit 3 and the page in bits 2:0.
- R3: Offsets 0x00 to 0x06 return the same data on every page. A read of 0x00 returns 0x4850, and writes to 0x00 change nothing.
- R4: A write to offset 0x04 with byte enable 0 sets every bit of 7:1 that is written as 1 when bit 0 is 1, and clears those bits when bit 0 is 0. The other bits of the low byte keep their value, and bit 0 always reads 0.
- R5: In the same way, the upper byte (bits 15:9) of offsets 0x04 and 0x06 is set or cleared under flag bit 8, but only when byte enable 1 is set. Bit 8 always reads 0. A lane whose byte enable is 0 keeps its value.
- R6: `core_rst_n` equals bit 1 of the low option word, so 0 holds the core in reset and 1 releases it.
- R7: In the high option word, bit 2 (advance to next receive packet) is cleared by a pulse on `adv_done`, and bit 1 (transmit command) is cleared by a pulse on `tx_done`. If a host write sets the bit in the same cycle as the pulse, the bit ends set.
- R8: On page 4, offset 0x10 reads the 12-bit dropped-packet count in bits 11:0, and offset 0x12 reads the CRC-error count in bits 7:0 and the aborted-transmit count in bits 15:8. A read clears the dropped count when any byte enable is set. It clears the CRC count when byte enable 0 is set, and the abort count when byte enable 1 is set.
- R9: If an increment pulse arrives in the same cycle as a clearing read of that counter, the read returns the old value and the counter holds 1 afterwards.
- R10: A counter at all-ones stays at all-ones when it receives further increments.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 in every other cycle. A read of an offset that is not decoded on the current page returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset (bit 0 ignored) |
| bus_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read strobe |
| adv_done | input | 1 | Receive-advance completion pulse |
| tx_done | input | 1 | Transmit-command completion pulse |
| inc_dropped | input | 1 | Dropped-packet increment pulse |
| inc_crc | input | 1 | CRC-error increment pulse |
| inc_abort | input | 1 | Aborted-transmit increment pulse |
| page_sel | output | 3 | Current page |
| opt_lo | output | 16 | Low option word |
| opt_hi | output | 16 | High option word |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
Every state change (page, option bits, command-bit clearing, counter clear and increment) takes effect at the clock edge that samples the strobe or pulse. Read data for a strobe is due in the very next cycle. The bench drives every input on the falling edge and samples one nanosecond after the rising edge. At that point it compares `bus_rdata` against the model value from before the edge, and the page, option words and `core_rst_n` against the model value after the edge. The model therefore advances exactly one edge per step, so no result is looked for a cycle early or late. The same-cycle collisions (done pulse against a host set, increment against a clearing read) and counter saturation are driven as directed cases. A seeded random phase then mixes writes, reads and pulses across all pages.

// File: rtl/netreg_pkg.sv
// Package: shared offsets, field positions and widths for the paged register bank.
// Assumes word-aligned 16-bit access; bit 0 of the offset is ignored.
package netreg_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int LANES    = 2;
    localparam int PFIELD_W = 4;   // width of the page field in a write

    localparam logic [ADDR_W-1:0] OFS_HWID  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PAGE  = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_OPTLO = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_OPTHI = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_DROP  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_ERRS  = 5'h12;

    localparam int OPTLO_RST_BIT = 1;
    localparam int OPTHI_TX_BIT  = 1;
    localparam int OPTHI_ADV_BIT = 2;
endpackage

// File: rtl/netreg_satcnt.sv
// Module: saturating event counter with clear-on-read.
// Assumes clr and inc are single-cycle qualified pulses; clr with inc leaves 1.
module netreg_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count pulses, stop at all-ones, reset on clear (keeping a coincident pulse).
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= inc ? W'(1) : '0;
        else if (inc && count != TOP)
            count <= count + W'(1);
    end

    assert_clr_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (count == W'(1)))
        else $error("counter did not hold 1 after clear with increment");

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (count == '0))
        else $error("counter did not clear on read");

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> (count == TOP))
        else $error("saturated counter moved");
endmodule

// File: rtl/netreg_setclr.sv
// Module: option word written by per-lane set/clear masks.
// Assumes the lowest bit of each lane is the flag and is never stored.
// Bits in AUTO_MASK are cleared by hw_clr unless a host set lands in the same cycle.
module netreg_setclr #(
    parameter int                 W         = 16,
    parameter int                 NLANE     = 2,
    parameter logic [W-1:0]       AUTO_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NLANE-1:0] be,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     hw_clr,
    output logic [W-1:0]     q_r
);
    localparam int LW = W / NLANE;

    logic [W-1:0] q_nxt;

    // Apply hardware clears first, then each enabled lane's set or clear mask.
    always_comb begin
        logic [LW-1:0] msk;
        msk   = '0;
        q_nxt = q_r & ~(hw_clr & AUTO_MASK);
        for (int l = 0; l < NLANE; l++) begin
            msk = wdata[l*LW +: LW] & ~LW'(1);
            if (wr_en && be[l]) begin
                if (wdata[l*LW])
                    q_nxt[l*LW +: LW] = q_nxt[l*LW +: LW] | msk;
                else
                    q_nxt[l*LW +: LW] = q_nxt[l*LW +: LW] & ~msk;
            end
        end
    end

    // Hold the option word.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && be[l] && wdata[l*LW] && wdata[l*LW+1]) |=> q_r[l*LW+1])
            else $error("lane set did not take");
        assert_lane_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!be[l] && !(|(hw_clr[l*LW +: LW] & AUTO_MASK[l*LW +: LW])))
            |=> $stable(q_r[l*LW +: LW]))
            else $error("disabled lane changed");
    end

    for (genvar b = 0; b < W; b++) begin : g_auto
        if (AUTO_MASK[b]) begin : g_on
            assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_clr[b] && !wr_en) |=> !q_r[b])
                else $error("command bit not cleared by completion");
        end
    end
endmodule

// File: rtl/netreg_bank.sv
// Module: paged host register bank (top).
// Common words at 0x00-0x06 on every page; page 4 carries clear-on-read counters.
// Assumes bus_rd and bus_wr are never high together.
module netreg_bank
    import netreg_pkg::*;
#(
    parameter int          NPAGES    = 8,
    parameter int          STAT_PAGE = 4,
    parameter int          DROP_W    = 12,
    parameter int          ERR_W     = 8,
    parameter logic [15:0] HW_ID     = 16'h4850,
    parameter logic [11:0] CARD_ID   = 12'h535
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        adv_done,
    input  logic        tx_done,
    input  logic        inc_dropped,
    input  logic        inc_crc,
    input  logic        inc_abort,
    output logic [2:0]  page_sel,
    output logic [15:0] opt_lo,
    output logic [15:0] opt_hi,
    output logic        core_rst_n
);
    localparam int PW = $clog2(NPAGES);
    localparam logic [DATA_W-1:0] HI_AUTO =
        DATA_W'((1 << OPTHI_ADV_BIT) | (1 << OPTHI_TX_BIT));

    logic [ADDR_W-1:0] off;
    logic              stat_sel;
    logic              wr_lo, wr_hi;
    logic              clr_drop, clr_crc, clr_abt;
    logic [DATA_W-1:0] hi_clr;
    logic [DROP_W-1:0] cnt_drop;
    logic [ERR_W-1:0]  cnt_crc, cnt_abt;
    logic [DATA_W-1:0] rd_mux;

    // Decode the word offset and which writes and clearing reads hit.
    always_comb begin
        off      = {bus_addr[ADDR_W-1:1], 1'b0};
        stat_sel = (page_sel == PW'(STAT_PAGE));
        wr_lo    = bus_wr && (off == OFS_OPTLO);
        wr_hi    = bus_wr && (off == OFS_OPTHI);
        clr_drop = bus_rd && stat_sel && (off == OFS_DROP) && (|bus_be);
        clr_crc  = bus_rd && stat_sel && (off == OFS_ERRS) && bus_be[0];
        clr_abt  = bus_rd && stat_sel && (off == OFS_ERRS) && bus_be[1];
        hi_clr   = '0;
        hi_clr[OPTHI_ADV_BIT] = adv_done;
        hi_clr[OPTHI_TX_BIT]  = tx_done;
    end

    // Paging register: accept only page numbers that exist.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_sel <= '0;
        else if (bus_wr && off == OFS_PAGE && bus_be[0] &&
                 ({1'b0, bus_wdata[PFIELD_W-1:0]} < (PFIELD_W+1)'(NPAGES)))
            page_sel <= bus_wdata[PW-1:0];
    end

    netreg_setclr #(.W(DATA_W), .NLANE(LANES), .AUTO_MASK('0)) u_opt_lo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_lo), .be(bus_be),
        .wdata(bus_wdata), .hw_clr('0), .q_r(opt_lo));

    netreg_setclr #(.W(DATA_W), .NLANE(LANES), .AUTO_MASK(HI_AUTO)) u_opt_hi (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hi), .be(bus_be),
        .wdata(bus_wdata), .hw_clr(hi_clr), .q_r(opt_hi));

    assign core_rst_n = opt_lo[OPTLO_RST_BIT];

    netreg_satcnt #(.W(DROP_W)) u_cnt_drop (
        .clk(clk), .rst_n(rst_n), .inc(inc_dropped), .clr(clr_drop), .count(cnt_drop));
    netreg_satcnt #(.W(ERR_W)) u_cnt_crc (
        .clk(clk), .rst_n(rst_n), .inc(inc_crc), .clr(clr_crc), .count(cnt_crc));
    netreg_satcnt #(.W(ERR_W)) u_cnt_abt (
        .clk(clk), .rst_n(rst_n), .inc(inc_abort), .clr(clr_abt), .count(cnt_abt));

    // Select the word for the current offset and page; undecoded reads give 0.
    always_comb begin
        rd_mux = '0;
        unique case (off)
            OFS_HWID:  rd_mux = HW_ID;
            OFS_PAGE:  rd_mux = {CARD_ID, {(PFIELD_W-PW){1'b0}}, page_sel};
            OFS_OPTLO: rd_mux = opt_lo;
            OFS_OPTHI: rd_mux = opt_hi;
            OFS_DROP:  if (stat_sel) rd_mux = DATA_W'(cnt_drop);
            OFS_ERRS:  if (stat_sel) rd_mux = {cnt_abt, cnt_crc};
            default:   rd_mux = '0;
        endcase
    end

    // Register read data for one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rd_mux : '0;
    end

    assert_bad_page_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFS_PAGE && bus_wdata[3]) |=> $stable(page_sel))
        else $error("out-of-range page accepted");

    assert_undecoded_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !stat_sel && off >= ADDR_W'(8)) |=> (bus_rdata == '0))
        else $error("undecoded read returned data");

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0))
        else $error("read data outside read cycle");
endmodule

// File: tb/netreg_bank_tb.sv
// Bench: directed corners plus seeded random traffic against a bench-side model.
module netreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        adv_done = 0, tx_done = 0;
    logic        inc_dropped = 0, inc_crc = 0, inc_abort = 0;
    logic [2:0]  page_sel;
    logic [15:0] opt_lo, opt_hi;
    logic        core_rst_n;

    int checks = 0;
    int errors = 0;

    // model state
    logic [2:0]  m_page = '0;
    logic [15:0] m_lo = '0, m_hi = '0;
    logic [11:0] m_drop = '0;
    logic [7:0]  m_crc = '0, m_abt = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    netreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .adv_done(adv_done), .tx_done(tx_done),
        .inc_dropped(inc_dropped), .inc_crc(inc_crc), .inc_abort(inc_abort),
        .page_sel(page_sel), .opt_lo(opt_lo), .opt_hi(opt_hi),
        .core_rst_n(core_rst_n));

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] setclr(input logic [15:0] old,
                                           input logic [15:0] wd, input logic [1:0] be);
        logic [15:0] r = old;
        for (int l = 0; l < 2; l++) begin
            logic [7:0] m = wd[l*8 +: 8] & 8'hFE;
            if (be[l]) r[l*8 +: 8] = wd[l*8] ? (r[l*8 +: 8] | m) : (r[l*8 +: 8] & ~m);
        end
        return r;
    endfunction

    function automatic logic [15:0] mread(input logic [4:0] a);
        case ({a[4:1], 1'b0})
            5'h00: return 16'h4850;
            5'h02: return {12'h535, 1'b0, m_page};
            5'h04: return m_lo;
            5'h06: return m_hi;
            5'h10: return (m_page == 3'd4) ? {4'h0, m_drop} : 16'h0;
            5'h12: return (m_page == 3'd4) ? {m_abt, m_crc} : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    // One bus cycle: drive on falling edge, advance model at rising edge, compare after it.
    task automatic step(input string tag, input bit wr, input bit rd, input logic [4:0] a,
                        input logic [1:0] be, input logic [15:0] wd,
                        input bit ad, input bit td, input bit idr, input bit icr, input bit iab);
        logic [15:0] exp_rd;
        logic [4:0]  o;
        bit          s4;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_be = be; bus_wdata = wd;
        adv_done = ad; tx_done = td; inc_dropped = idr; inc_crc = icr; inc_abort = iab;
        @(posedge clk);
        o = {a[4:1], 1'b0};
        s4 = (m_page == 3'd4);
        exp_rd = rd ? mread(a) : 16'h0;
        // counters: clear on read, then increment (coincident pulse leaves 1)
        if (rd && s4 && o == 5'h10 && |be) m_drop = idr ? 12'd1 : 12'd0;
        else if (idr && m_drop != 12'hFFF) m_drop = m_drop + 12'd1;
        if (rd && s4 && o == 5'h12 && be[0]) m_crc = icr ? 8'd1 : 8'd0;
        else if (icr && m_crc != 8'hFF) m_crc = m_crc + 8'd1;
        if (rd && s4 && o == 5'h12 && be[1]) m_abt = iab ? 8'd1 : 8'd0;
        else if (iab && m_abt != 8'hFF) m_abt = m_abt + 8'd1;
        if (ad) m_hi[2] = 1'b0;
        if (td) m_hi[1] = 1'b0;
        if (wr && o == 5'h04) m_lo = setclr(m_lo, wd, be);
        if (wr && o == 5'h06) m_hi = setclr(m_hi, wd, be);
        if (wr && o == 5'h02 && be[0] && wd[3:0] < 4'd8) m_page = wd[2:0];
        #1;
        check(tag, "rdata", bus_rdata, exp_rd);
        check(tag, "page", {13'h0, page_sel}, {13'h0, m_page});
        check(tag, "opt_lo", opt_lo, m_lo);
        check(tag, "opt_hi", opt_hi, m_hi);
        check(tag, "core_rst_n", {15'h0, core_rst_n}, {15'h0, m_lo[1]});
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; adv_done = 0; tx_done = 0;
        inc_dropped = 0; inc_crc = 0; inc_abort = 0;
    endtask

    task automatic wr(input string t, input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
        step(t, 1, 0, a, be, d, 0, 0, 0, 0, 0);
    endtask
    task automatic rd(input string t, input logic [4:0] a, input logic [1:0] be);
        step(t, 0, 1, a, be, 16'h0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        // R1: reset state at the ports
        check("R1", "page", {13'h0, page_sel}, 16'h0);
        check("R1", "opt_lo", opt_lo, 16'h0);
        check("R1", "opt_hi", opt_hi, 16'h0);
        check("R1", "core_rst_n", {15'h0, core_rst_n}, 16'h0);
        check("R1", "rdata", bus_rdata, 16'h0);
        wr("R1", 5'h02, 2'b11, 16'h0004);
        rd("R1", 5'h10, 2'b11);
        rd("R1", 5'h12, 2'b11);
        wr("R1", 5'h02, 2'b11, 16'h0000);

        // R3: identifier and common words on several pages; write to 0x00 ignored
        rd("R3", 5'h00, 2'b11);
        wr("R3", 5'h00, 2'b11, 16'hFFFF);
        rd("R3", 5'h00, 2'b11);
        wr("R3", 5'h02, 2'b01, 16'h0005);
        rd("R3", 5'h00, 2'b11);
        rd("R3", 5'h02, 2'b11);

        // R2: page value 9 and 15 ignored, 7 accepted
        wr("R2", 5'h02, 2'b01, 16'h0009);
        rd("R2", 5'h02, 2'b11);
        wr("R2", 5'h02, 2'b01, 16'h000F);
        wr("R2", 5'h02, 2'b01, 16'h0007);
        rd("R2", 5'h02, 2'b11);

        // R4/R6: set reset-release bit, then clear it
        wr("R4", 5'h04, 2'b01, 16'h0003);
        check("R6", "core_rst_n", {15'h0, core_rst_n}, 16'h1);
        wr("R4", 5'h04, 2'b01, 16'h00F1);
        wr("R4", 5'h04, 2'b01, 16'h0022);
        rd("R4", 5'h04, 2'b11);
        check("R6", "core_rst_n", {15'h0, core_rst_n}, 16'h0);

        // R5: upper lane with and without its enable
        wr("R5", 5'h04, 2'b10, 16'h4100);
        wr("R5", 5'h04, 2'b01, 16'h8101);
        wr("R5", 5'h04, 2'b11, 16'h4000);
        wr("R5", 5'h06, 2'b10, 16'hFF00);
        rd("R5", 5'h06, 2'b11);

        // R7: completion pulses clear command bits; same-cycle set wins
        wr("R7", 5'h06, 2'b01, 16'h0007);
        step("R7", 0, 0, 5'h0, 2'b00, 16'h0, 0, 1, 0, 0, 0);
        step("R7", 0, 0, 5'h0, 2'b00, 16'h0, 1, 0, 0, 0, 0);
        wr("R7", 5'h06, 2'b01, 16'h0007);
        step("R7", 1, 0, 5'h06, 2'b01, 16'h0003, 0, 1, 0, 0, 0);
        step("R7", 0, 1, 5'h06, 2'b11, 16'h0, 1, 1, 0, 0, 0);

        // R8: counters on page 4, per-lane clearing
        wr("R8", 5'h02, 2'b01, 16'h0004);
        for (int i = 0; i < 5; i++) step("R8", 0, 0, 5'h0, 2'b00, 16'h0, 0, 0, 1, 1, 1);
        rd("R8", 5'h12, 2'b01);
        rd("R8", 5'h12, 2'b11);
        rd("R8", 5'h10, 2'b10);
        rd("R8", 5'h10, 2'b11);

        // R9: increment with clearing read
        step("R9", 0, 0, 5'h0, 2'b00, 16'h0, 0, 0, 1, 1, 1);
        step("R9", 0, 1, 5'h10, 2'b11, 16'h0, 0, 0, 1, 0, 0);
        step("R9", 0, 1, 5'h12, 2'b11, 16'h0, 0, 0, 0, 1, 1);
        rd("R9", 5'h10, 2'b11);
        rd("R9", 5'h12, 2'b11);

        // R10: saturation of both widths
        for (int i = 0; i < 4100; i++) step("R10", 0, 0, 5'h0, 2'b00, 16'h0, 0, 0, 1, 1, 1);
        rd("R10", 5'h10, 2'b11);
        rd("R10", 5'h12, 2'b11);

        // R11: undecoded offsets
        rd("R11", 5'h18, 2'b11);
        rd("R11", 5'h0A, 2'b11);
        wr("R11", 5'h02, 2'b01, 16'h0002);
        rd("R11", 5'h10, 2'b11);
        rd("R11", 5'h12, 2'b11);

        // random mixed traffic
        for (int i = 0; i < 600; i++) begin
            int          k = $urandom_range(0, 3);
            logic [4:0]  a = 5'($urandom_range(0, 15) << 1);
            logic [1:0]  be = 2'($urandom_range(0, 3));
            logic [15:0] d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) a = 5'h02;
            if (a == 5'h02) d[3:0] = 4'($urandom_range(0, 15));
            step("RAND", k == 0, k == 1, a, be, d,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 2) == 0);
        end
        finish_run();
    end
endmodule